// File: doc/BRIEF.md
# Prioritized Interrupt Mask Arbiter

This block stands between seven interrupt request lines and a processor core. Each line carries one fixed priority level. The block finds the highest level that is currently requesting. It then compares that level with the 3-bit priority mask the core takes from its status word. When the level wins, the block raises a request toward the core. When the core acknowledges, the block runs a short acknowledge cycle toward the devices.

During the acknowledge cycle a device may return a vector number. When it does, the block turns that number into a vector-table byte address. If no usable device vector arrives within a bounded window, the block falls back to an autovector derived from the level. When the cycle completes, the block pulses a completion strobe. With that strobe it hands the core three things: the table address, the new mask value (the accepted level), and a strobe that tells the core to enter supervisor mode.

The top line is non-maskable. Its request is taken from rising edges, so a line held high produces one service and no more.

Top module: `irq_mask_arbiter`

## Requirements
- R1: After reset, `intr_req`, `iack`, `done` and `sup_set` are low, and no edge of the top line is pending.
- R2: Line k (k = 0..5) carries level k+1. The top line (index 6) carries level 7. `req_level` shows the highest level requesting, or 0 when none is.
- R3: A level from 1 to 6 raises `intr_req` only when it is strictly greater than `cpu_mask`. A level equal to or below the mask leaves `intr_req` low.
- R4: A rising edge on line 6 (sampled on the clock) makes level 7 pending from the next cycle on. Level 7 is requested whatever `cpu_mask` holds. Acceptance clears the pending edge, so a line held high is serviced once; it needs a new low-to-high transition to request again.
- R5: An edge where `core_ack` and `intr_req` are both high captures `req_level`. From the next cycle, `iack` is high and `iack_level` holds the captured level. While `iack` is high, `intr_req` stays low and further `core_ack` has no effect.
- R6: An edge inside the acknowledge cycle where `vec_valid` is high and `vec_num` is 64 or more ends the cycle. In the next cycle `done` pulses for one cycle, `vec_addr` equals `vec_num`×4, and `iack` is low.
- R7: A device vector below 64 is treated as absent. The acknowledge cycle continues as though `vec_valid` were low.
- R8: If no usable vector is seen on the first TIMEOUT edges of the acknowledge cycle (default 8), `done` pulses after the last of them with `vec_addr` = (24 + level)×4.
- R9: While `done` is high, `sup_set` is high and `new_mask` equals the accepted level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 7 | Request lines; index k is level k+1, index 6 is the non-maskable edge line |
| cpu_mask | input | 3 | Current priority mask from the core status word |
| core_ack | input | 1 | Core takes the offered interrupt |
| vec_valid | input | 1 | Device drives a vector number during the acknowledge cycle |
| vec_num | input | 8 | Device vector number |
| intr_req | output | 1 | A request beats the mask and the block is idle |
| req_level | output | 3 | Highest requesting level (0 = none) |
| iack | output | 1 | Acknowledge cycle in progress toward the devices |
| iack_level | output | 3 | Level being acknowledged |
| done | output | 1 | One-cycle completion strobe |
| vec_addr | output | 10 | Vector-table byte address, valid with done |
| new_mask | output | 3 | Mask the core must load, valid with done |
| sup_set | output | 1 | Enter supervisor mode, valid with done |

## Verification
The bench targets these cases:
- **Mask equal to the request level.** A `>=` comparison would wrongly raise `intr_req` here.
- **The non-maskable line.** It is checked under mask 7, while held high across and after its own service, and when re-raised after a drop. A level-sensitive design would service it repeatedly. A masked one would never service it.
- **Vector timing.** A reserved vector number is offered, and so is a late vector at the last edge of the window. An off-by-one timer, or a design that accepts low vectors, shows up there as a wrong `vec_addr` or a shifted `done`.
- **Competing requests.** Several lines are raised at once, including level 7 arriving while another level is in its acknowledge cycle. This checks the highest-wins choice and that the pending edge is kept.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int LVL_W     = 3;
  localparam int NLINES    = (1 << LVL_W) - 1;
  localparam int NMI_LVL   = NLINES;
  localparam int VEC_W     = 8;
  localparam int ADDR_W    = VEC_W + 2;
  localparam int AUTO_BASE = 24;
  localparam int USER_MIN  = 64;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_st_t;

  function automatic logic [ADDR_W-1:0] vec_to_addr(input logic [VEC_W-1:0] v);
    return {v, 2'b00};
  endfunction

  function automatic logic [VEC_W-1:0] autovec(input logic [LVL_W-1:0] lvl);
    return VEC_W'(AUTO_BASE) + VEC_W'(lvl);
  endfunction

  function automatic logic lvl_beats_mask(input logic [LVL_W-1:0] lvl,
                                          input logic [LVL_W-1:0] mask);
    if (lvl == '0) return 1'b0;
    if (lvl == LVL_W'(NMI_LVL)) return 1'b1;
    return lvl > mask;
  endfunction

  function automatic logic vec_usable(input logic [VEC_W-1:0] v);
    return v >= VEC_W'(USER_MIN);
  endfunction
endpackage

// File: rtl/irqa_nmi_edge.sv
module irqa_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clear_i,
  output logic pend_o
);
  logic prev_q;
  logic rise_w;

  assign rise_w = line_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_o <= (pend_o & ~clear_i) | rise_w;
    end
  end

  assert_nmi_from_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(line_i));
endmodule

// File: rtl/irqa_prio_pick.sv
module irqa_prio_pick
  import irqa_pkg::*;
(
  input  logic [NLINES-1:0] req_i,
  output logic [NLINES-1:0] grant_oh_o,
  output logic [LVL_W-1:0]  lvl_o
);
  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_win
      if (g == NLINES - 1) begin : g_top
        assign grant_oh_o[g] = req_i[g];
      end else begin : g_low
        assign grant_oh_o[g] = req_i[g] & ~(|req_i[NLINES-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (grant_oh_o[i]) lvl_o = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/irqa_vec_seq.sv
module irqa_vec_seq
  import irqa_pkg::*;
#(
  parameter int TIMEOUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              vec_valid_i,
  input  logic [VEC_W-1:0]  vec_num_i,
  output logic              idle_o,
  output logic              iack_o,
  output logic [LVL_W-1:0]  iack_lvl_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [LVL_W-1:0]  new_mask_o
);
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  seq_st_t           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              dev_hit_w;
  logic              expire_w;

  assign dev_hit_w  = vec_valid_i & vec_usable(vec_num_i);
  assign expire_w   = (cnt_q == CNT_W'(TIMEOUT - 1));
  assign idle_o     = (st_q == ST_IDLE);
  assign iack_o     = (st_q == ST_WAIT);
  assign iack_lvl_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      lvl_q      <= '0;
      done_o     <= 1'b0;
      vec_addr_o <= '0;
      new_mask_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take_i) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
            lvl_q <= lvl_i;
          end
        end
        ST_WAIT: begin
          if (dev_hit_w) begin
            st_q       <= ST_IDLE;
            done_o     <= 1'b1;
            vec_addr_o <= vec_to_addr(vec_num_i);
            new_mask_o <= lvl_q;
          end else if (expire_w) begin
            st_q       <= ST_IDLE;
            done_o     <= 1'b1;
            vec_addr_o <= vec_to_addr(autovec(lvl_q));
            new_mask_o <= lvl_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> (int'(cnt_q) < TIMEOUT));

  assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((vec_addr_o >= ADDR_W'(USER_MIN * 4)) ||
                ((vec_addr_o >= ADDR_W'(AUTO_BASE * 4)) &&
                 (vec_addr_o <= ADDR_W'((AUTO_BASE + NMI_LVL) * 4)))));

  assert_mask_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (new_mask_o != '0));

  assert_done_ends_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !iack_o);
endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter
  import irqa_pkg::*;
#(
  parameter int TIMEOUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic              core_ack,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_num,
  output logic              intr_req,
  output logic [LVL_W-1:0]  req_level,
  output logic              iack,
  output logic [LVL_W-1:0]  iack_level,
  output logic              done,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [LVL_W-1:0]  new_mask,
  output logic              sup_set
);
  logic              nmi_pend_w;
  logic              nmi_clear_w;
  logic [NLINES-1:0] eff_req_w;
  logic [NLINES-1:0] grant_oh_w;
  logic              idle_w;
  logic              take_w;

  assign eff_req_w = {nmi_pend_w, irq_lines[NLINES-2:0]};

  irqa_nmi_edge u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (irq_lines[NLINES-1]),
    .clear_i (nmi_clear_w),
    .pend_o  (nmi_pend_w)
  );

  irqa_prio_pick u_pick (
    .req_i      (eff_req_w),
    .grant_oh_o (grant_oh_w),
    .lvl_o      (req_level)
  );

  assign intr_req    = idle_w & lvl_beats_mask(req_level, cpu_mask);
  assign take_w      = intr_req & core_ack;
  assign nmi_clear_w = take_w & grant_oh_w[NLINES-1];

  irqa_vec_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_w),
    .lvl_i       (req_level),
    .vec_valid_i (vec_valid),
    .vec_num_i   (vec_num),
    .idle_o      (idle_w),
    .iack_o      (iack),
    .iack_lvl_o  (iack_level),
    .done_o      (done),
    .vec_addr_o  (vec_addr),
    .new_mask_o  (new_mask)
  );

  assign sup_set = done;

  assert_quiet_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> !intr_req);

  assert_ack_needs_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack) |-> ($past(core_ack) && $past(intr_req)));

  assert_lvl_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && $past(iack)) |-> $stable(iack_level));

  assert_level_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_req_w != '0) |-> (req_level != '0));
endmodule

// File: tb/irq_mask_arbiter_tb.sv
module irq_mask_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_lines = '0;
  logic [2:0] cpu_mask = '0;
  logic       core_ack = 1'b0;
  logic       vec_valid = 1'b0;
  logic [7:0] vec_num = '0;
  logic       intr_req, iack, done, sup_set;
  logic [2:0] req_level, iack_level, new_mask;
  logic [9:0] vec_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  irq_mask_arbiter #(.TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cpu_mask(cpu_mask),
    .core_ack(core_ack), .vec_valid(vec_valid), .vec_num(vec_num),
    .intr_req(intr_req), .req_level(req_level), .iack(iack),
    .iack_level(iack_level), .done(done), .vec_addr(vec_addr),
    .new_mask(new_mask), .sup_set(sup_set)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_busy = 0, m_cnt = 0, m_lvl = 0, m_prev = 0, m_pend = 0;
  int m_done = 0, m_addr = 0, m_mask = 0;

  function automatic int ref_level(logic [6:0] l, int pend);
    int best = 0;
    for (int k = 0; k < 6; k++) if (l[k]) best = k + 1;
    if (pend != 0) best = 7;
    return best;
  endfunction

  function automatic int ref_req(int lvl, int mask, int busy);
    if (busy != 0 || lvl == 0) return 0;
    if (lvl == 7) return 1;
    return (lvl > mask) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_lvl = 0; m_prev = 0; m_pend = 0;
      m_done = 0; m_addr = 0; m_mask = 0;
    end else begin
      int lvl, tk, rise;
      lvl  = ref_level(irq_lines, m_pend);
      tk   = (ref_req(lvl, cpu_mask, m_busy) != 0 && core_ack) ? 1 : 0;
      rise = (irq_lines[6] && m_prev == 0) ? 1 : 0;
      m_prev = irq_lines[6];
      m_pend = ((m_pend != 0 && !(tk != 0 && lvl == 7)) || rise != 0) ? 1 : 0;
      m_done = 0;
      if (m_busy == 0) begin
        if (tk != 0) begin m_busy = 1; m_cnt = 0; m_lvl = lvl; end
      end else if (vec_valid && vec_num >= 64) begin
        m_done = 1; m_addr = vec_num * 4; m_mask = m_lvl; m_busy = 0;
      end else if (m_cnt == TO - 1) begin
        m_done = 1; m_addr = (24 + m_lvl) * 4; m_mask = m_lvl; m_busy = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int lvl;
    lvl = ref_level(irq_lines, m_pend);
    chk("R2 req_level", req_level, lvl);
    chk("R3 R4 intr_req", intr_req, ref_req(lvl, cpu_mask, m_busy));
    chk("R5 iack", iack, m_busy);
    if (m_busy != 0) chk("R5 iack_level", iack_level, m_lvl);
    chk("R6 R8 done", done, m_done);
    chk("R9 sup_set", sup_set, m_done);
    if (m_done != 0) begin
      chk("R6 R7 R8 vec_addr", vec_addr, m_addr);
      chk("R9 new_mask", new_mask, m_mask);
    end
  endtask

  task automatic cyc(logic [6:0] l, logic [2:0] mk, logic ak, logic vv, logic [7:0] vn);
    @(negedge clk);
    irq_lines = l; cpu_mask = mk; core_ack = ak; vec_valid = vv; vec_num = vn;
    #1 compare_all();
  endtask

  task automatic idle_n(int n, logic [6:0] l, logic [2:0] mk);
    for (int i = 0; i < n; i++) cyc(l, mk, 1'b0, 1'b0, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1: reset state
    chk("R1 intr_req", intr_req, 0);
    chk("R1 iack", iack, 0);
    chk("R1 done", done, 0);
    chk("R1 sup_set", sup_set, 0);
    @(negedge clk); rst_n = 1'b1;
    idle_n(2, 7'h00, 3'd0);

    // R3: equal to mask stays low, above mask raises
    idle_n(2, 7'b0000100, 3'd3);
    idle_n(2, 7'b0000100, 3'd2);
    // R2: highest of several wins
    idle_n(2, 7'b0010101, 3'd0);
    idle_n(2, 7'b0100001, 3'd6);

    // R5 R6: accept level 5, device vector 64
    cyc(7'b0010001, 3'd2, 1'b1, 1'b0, 8'd0);
    cyc(7'b0010001, 3'd2, 1'b1, 1'b0, 8'd0);
    cyc(7'b0010001, 3'd2, 1'b0, 1'b1, 8'd64);
    idle_n(2, 7'b0000000, 3'd5);

    // R7 R8: reserved vector then timeout autovector
    cyc(7'b0000010, 3'd0, 1'b1, 1'b0, 8'd0);
    for (int i = 0; i < TO + 2; i++) cyc(7'b0000010, 3'd0, 1'b0, 1'b1, 8'd10);
    idle_n(2, 7'b0, 3'd0);

    // R8: vector on last edge of window
    cyc(7'b0001000, 3'd1, 1'b1, 1'b0, 8'd0);
    for (int i = 0; i < TO - 1; i++) cyc(7'b0001000, 3'd1, 1'b0, 1'b0, 8'd0);
    cyc(7'b0001000, 3'd1, 1'b0, 1'b1, 8'd255);
    idle_n(2, 7'b0, 3'd0);

    // R4: top line under mask 7, held high
    idle_n(2, 7'b1000000, 3'd7);
    cyc(7'b1000000, 3'd7, 1'b1, 1'b0, 8'd0);
    for (int i = 0; i < TO + 2; i++) cyc(7'b1000000, 3'd7, 1'b1, 1'b0, 8'd0);
    idle_n(3, 7'b1000000, 3'd7);
    // drop and raise again
    idle_n(1, 7'b0000000, 3'd7);
    idle_n(2, 7'b1000000, 3'd7);
    cyc(7'b1000000, 3'd7, 1'b1, 1'b0, 8'd0);
    cyc(7'b1000000, 3'd7, 1'b0, 1'b1, 8'd200);
    idle_n(2, 7'b0, 3'd0);

    // R4: top-line edge arrives while level 2 is being acknowledged
    cyc(7'b0000010, 3'd0, 1'b1, 1'b0, 8'd0);
    cyc(7'b1000010, 3'd0, 1'b0, 1'b0, 8'd0);
    cyc(7'b0000010, 3'd0, 1'b0, 1'b1, 8'd90);
    idle_n(2, 7'b0000010, 3'd2);
    cyc(7'b0000010, 3'd2, 1'b1, 1'b0, 8'd0);
    for (int i = 0; i < TO + 2; i++) cyc(7'b0000010, 3'd2, 1'b0, 1'b0, 8'd0);
    idle_n(2, 7'b0, 3'd7);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule